// File: doc/BRIEF.md
# Strided Framebuffer Fill Engine

This block paints one constant colour into a rectangle of a linear framebuffer that lives in byte-addressed external memory. A single command gives the address of the rectangle's top-left pixel, the colour, the pixel size, the number of pixels in each row and the number of rows. It also gives the row pitch, which is the distance in bytes from the start of one row to the start of the next. The engine writes one burst per row. It then moves the row start forward by the pitch and writes the next row. With a row of one pixel, the command draws a vertical line.

Pixels are 8, 16 or 32 bits wide. Each write beat is one aligned 32-bit bus word. The colour is spread across the four byte lanes so that every pixel's bytes fall on their own addresses, least significant byte first. Byte enables trim the first and last beat of a row when the row does not begin or end on a word boundary. Every write is a whole-byte write, so no read-modify-write is needed. The engine takes a new command only while it is idle, and it pulses `done` once the command has finished.

Top module: `fb_fill_engine`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `wr_valid` and `done` are 0. `cmd_ready` is high only while the engine is idle, and never together with `wr_valid` or `done`.
- R2: A command accepted with a run length of 0 or a line count of 0 produces no write beat. It raises `done` in the cycle after the acceptance edge.
- R3: `cmd_size` encodes the pixel size: 0 is 1 byte, 1 is 2 bytes, and 2 or 3 is 4 bytes. Each line covers exactly run × pixel-bytes consecutive byte addresses.
- R4: `wr_addr` is always a multiple of 4. A line's beats start at its start address rounded down to a multiple of 4 and step by 4 with no gaps. `wr_first` marks the first beat of a line and `wr_last` marks its last beat.
- R5: In the first beat of a line, byte lanes below the start-address offset (address mod 4) are disabled. In the last beat, lanes above the end-address offset are disabled. All other lanes are enabled.
- R6: Byte lane i of a beat at word address W holds byte number ((W+i − line start) mod pixel-bytes) of `cmd_pixel`, where byte 0 is bits 7:0.
- R7: Line k (counting from 0) starts at start + k × pitch, modulo 2^32. Exactly `cmd_lines` lines are written, in increasing k, and nothing is written after them.
- R8: `done` is high for exactly one cycle, in the cycle after the handshake of the final beat. `cmd_ready` is high again in the cycle after that.
- R9: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr`, `wr_data`, `wr_be`, `wr_first` and `wr_last` stay unchanged.
- R10: A `cmd_valid` pulse while `cmd_ready` is low has no effect. The write stream matches the command that is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle; a command is taken when this and `cmd_valid` are both high |
| cmd_addr | input | 32 | Byte address of the first pixel of the first line |
| cmd_pixel | input | 32 | Fill colour, with byte 0 in bits 7:0 |
| cmd_size | input | 2 | Pixel size code (R3) |
| cmd_run | input | 16 | Pixels per line |
| cmd_pitch | input | 32 | Byte distance from one line start to the next |
| cmd_lines | input | 16 | Number of lines |
| wr_valid | output | 1 | Write beat valid |
| wr_ready | input | 1 | Memory side accepts the beat |
| wr_addr | output | 32 | Word-aligned byte address of the beat |
| wr_data | output | 32 | Beat data |
| wr_be | output | 4 | Byte enables, one per byte lane |
| wr_first | output | 1 | First beat of a line burst |
| wr_last | output | 1 | Last beat of a line burst |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a line whose start offset within the bus word is not a multiple of the pixel size. Examples are a 16-bit pixel at an odd address, or a 32-bit pixel at offset 3. In these cases the colour bytes must rotate across the lanes, and the first and last masks cut through a pixel. If the pitch is not a multiple of 4, the rotation also changes from one line to the next. The stimulus covers this with directed commands at such offsets, using vertical lines with odd pitches. It adds seeded random commands whose address, pitch and size are drawn without any alignment, with a randomly stalling `wr_ready`. Some commands also carry junk requests while the engine is busy.

// File: rtl/fb_fill_pkg.sv
package fb_fill_pkg;

    localparam int FB_ADDR_W    = 32;
    localparam int FB_PIX_W     = 32;
    localparam int FB_BUS_BYTES = 4;
    localparam int FB_RUN_W     = 16;
    localparam int FB_LINE_W    = 16;

    localparam int FB_DATA_W = FB_BUS_BYTES * 8;
    localparam int FB_OFF_W  = $clog2(FB_BUS_BYTES);
    localparam int FB_WORD_W = FB_ADDR_W - FB_OFF_W;
    localparam int FB_LEN_W  = FB_RUN_W + 2;

    typedef enum logic [1:0] {
        FILL_IDLE  = 2'd0,
        FILL_BURST = 2'd1,
        FILL_DONE  = 2'd2
    } fill_state_e;

    typedef struct packed {
        logic [FB_ADDR_W-1:0] addr;
        logic [FB_PIX_W-1:0]  pixel;
        logic [1:0]           size;
        logic [FB_RUN_W-1:0]  run;
        logic [FB_ADDR_W-1:0] pitch;
        logic [FB_LINE_W-1:0] lines;
    } fill_cmd_t;

    // log2 of the bytes per pixel for a size code
    function automatic logic [1:0] pix_shift(input logic [1:0] code);
        case (code)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/fb_fill_span.sv
module fb_fill_span
    import fb_fill_pkg::*;
(
    input  logic [FB_ADDR_W-1:0] line_addr,
    input  logic [FB_LEN_W-1:0]  len_bytes,
    output logic [FB_ADDR_W-1:0] end_addr
);
    // address of the final byte of the line
    always_comb begin
        end_addr = line_addr + FB_ADDR_W'(len_bytes) - FB_ADDR_W'(1);
    end
endmodule

// File: rtl/fb_fill_lanes.sv
module fb_fill_lanes
    import fb_fill_pkg::*;
(
    input  logic [FB_PIX_W-1:0]  pixel,
    input  logic [1:0]           size,
    input  logic [FB_OFF_W-1:0]  start_off,
    input  logic [FB_OFF_W-1:0]  end_off,
    input  logic                 is_first,
    input  logic                 is_last,
    output logic [FB_DATA_W-1:0] data,
    output logic [FB_BUS_BYTES-1:0] be
);
    logic [1:0] byte_mask;

    always_comb begin
        byte_mask = 2'((3'd1 << pix_shift(size)) - 3'd1);
    end

    for (genvar i = 0; i < FB_BUS_BYTES; i++) begin : g_lane
        localparam logic [FB_OFF_W-1:0] LANE = FB_OFF_W'(i);
        logic [FB_OFF_W-1:0] rel;
        logic [1:0]          sel;
        always_comb begin
            rel = LANE - start_off;
            sel = rel[1:0] & byte_mask;
            data[i*8 +: 8] = pixel[sel*8 +: 8];
            be[i] = (!is_first || (LANE >= start_off)) &&
                    (!is_last  || (LANE <= end_off));
        end
    end
endmodule

// File: rtl/fb_fill_ctrl.sv
module fb_fill_ctrl
    import fb_fill_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cmd_valid,
    input  fill_cmd_t             cmd,
    input  logic                  wr_ready,
    input  logic [FB_ADDR_W-1:0]  end_addr,
    output logic                  cmd_ready,
    output logic                  wr_valid,
    output logic                  done,
    output logic                  is_first,
    output logic                  is_last,
    output logic [FB_WORD_W-1:0]  beat_word,
    output logic [FB_ADDR_W-1:0]  line_addr,
    output logic [FB_LEN_W-1:0]   len_bytes,
    output logic [FB_PIX_W-1:0]   pixel,
    output logic [1:0]            size
);
    fill_state_e          state;
    logic [FB_ADDR_W-1:0] pitch;
    logic [FB_LINE_W-1:0] lines_left;
    logic [FB_ADDR_W-1:0] next_line;
    logic                 cmd_empty;

    always_comb begin
        cmd_ready = (state == FILL_IDLE);
        wr_valid  = (state == FILL_BURST);
        done      = (state == FILL_DONE);
        is_first  = (beat_word == line_addr[FB_ADDR_W-1:FB_OFF_W]);
        is_last   = (beat_word == end_addr[FB_ADDR_W-1:FB_OFF_W]);
        next_line = line_addr + pitch;
        cmd_empty = (cmd.run == '0) || (cmd.lines == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= FILL_IDLE;
            line_addr  <= '0;
            beat_word  <= '0;
            pitch      <= '0;
            lines_left <= '0;
            len_bytes  <= '0;
            pixel      <= '0;
            size       <= '0;
        end else begin
            case (state)
                FILL_IDLE: begin
                    if (cmd_valid) begin
                        line_addr  <= cmd.addr;
                        beat_word  <= cmd.addr[FB_ADDR_W-1:FB_OFF_W];
                        pitch      <= cmd.pitch;
                        lines_left <= cmd.lines;
                        len_bytes  <= FB_LEN_W'(cmd.run) << pix_shift(cmd.size);
                        pixel      <= cmd.pixel;
                        size       <= cmd.size;
                        state      <= cmd_empty ? FILL_DONE : FILL_BURST;
                    end
                end
                FILL_BURST: begin
                    if (wr_ready) begin
                        if (!is_last) begin
                            beat_word <= beat_word + FB_WORD_W'(1);
                        end else if (lines_left == FB_LINE_W'(1)) begin
                            state <= FILL_DONE;
                        end else begin
                            lines_left <= lines_left - FB_LINE_W'(1);
                            line_addr  <= next_line;
                            beat_word  <= next_line[FB_ADDR_W-1:FB_OFF_W];
                        end
                    end
                end
                default: state <= FILL_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fb_fill_engine.sv
module fb_fill_engine
    import fb_fill_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cmd_valid,
    output logic                    cmd_ready,
    input  logic [FB_ADDR_W-1:0]    cmd_addr,
    input  logic [FB_PIX_W-1:0]     cmd_pixel,
    input  logic [1:0]              cmd_size,
    input  logic [FB_RUN_W-1:0]     cmd_run,
    input  logic [FB_ADDR_W-1:0]    cmd_pitch,
    input  logic [FB_LINE_W-1:0]    cmd_lines,
    output logic                    wr_valid,
    input  logic                    wr_ready,
    output logic [FB_ADDR_W-1:0]    wr_addr,
    output logic [FB_DATA_W-1:0]    wr_data,
    output logic [FB_BUS_BYTES-1:0] wr_be,
    output logic                    wr_first,
    output logic                    wr_last,
    output logic                    done
);
    fill_cmd_t            cmd;
    logic [FB_ADDR_W-1:0] end_addr;
    logic [FB_ADDR_W-1:0] line_addr;
    logic [FB_LEN_W-1:0]  len_bytes;
    logic [FB_WORD_W-1:0] beat_word;
    logic [FB_PIX_W-1:0]  pixel;
    logic [1:0]           size;
    logic                 is_first;
    logic                 is_last;

    always_comb begin
        cmd.addr  = cmd_addr;
        cmd.pixel = cmd_pixel;
        cmd.size  = cmd_size;
        cmd.run   = cmd_run;
        cmd.pitch = cmd_pitch;
        cmd.lines = cmd_lines;
        wr_addr   = {beat_word, {FB_OFF_W{1'b0}}};
        wr_first  = is_first;
        wr_last   = is_last;
    end

    fb_fill_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .wr_ready  (wr_ready),
        .end_addr  (end_addr),
        .cmd_ready (cmd_ready),
        .wr_valid  (wr_valid),
        .done      (done),
        .is_first  (is_first),
        .is_last   (is_last),
        .beat_word (beat_word),
        .line_addr (line_addr),
        .len_bytes (len_bytes),
        .pixel     (pixel),
        .size      (size)
    );

    fb_fill_span u_span (
        .line_addr (line_addr),
        .len_bytes (len_bytes),
        .end_addr  (end_addr)
    );

    fb_fill_lanes u_lanes (
        .pixel     (pixel),
        .size      (size),
        .start_off (line_addr[FB_OFF_W-1:0]),
        .end_off   (end_addr[FB_OFF_W-1:0]),
        .is_first  (is_first),
        .is_last   (is_last),
        .data      (wr_data),
        .be        (wr_be)
    );
endmodule

// File: rtl/fb_fill_checker.sv
module fb_fill_checker
    import fb_fill_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    cmd_valid,
    input logic                    cmd_ready,
    input logic                    wr_valid,
    input logic                    wr_ready,
    input logic [FB_ADDR_W-1:0]    wr_addr,
    input logic [FB_DATA_W-1:0]    wr_data,
    input logic [FB_BUS_BYTES-1:0] wr_be,
    input logic                    wr_first,
    input logic                    wr_last,
    input logic                    done
);
    // R1: idle excludes write traffic and completion
    a_r1_idle_exclusive: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> (!wr_valid && !done));

    // R4: beats are word aligned
    a_r4_word_aligned: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (wr_addr[FB_OFF_W-1:0] == '0));

    // R4: inside a line the next beat follows at the next word
    a_r4_addr_step: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready && !wr_last) |=>
            (wr_valid && !wr_first &&
             wr_addr == $past(wr_addr) + FB_ADDR_W'(FB_BUS_BYTES)));

    // R5: every beat enables at least one lane
    a_r5_be_nonzero: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (wr_be != '0));

    // R8: completion is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: completion follows a final beat or an empty command
    a_r8_done_cause: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(wr_valid && wr_ready && wr_last) ||
                  $past(cmd_valid && cmd_ready)));

    // R9: a stalled beat holds still
    a_r9_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=>
            (wr_valid && $stable(wr_addr) && $stable(wr_data) &&
             $stable(wr_be) && $stable(wr_first) && $stable(wr_last)));
endmodule

bind fb_fill_engine fb_fill_checker u_fb_fill_checker (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_be     (wr_be),
    .wr_first  (wr_first),
    .wr_last   (wr_last),
    .done      (done)
);

// File: tb/fb_fill_engine_tb_top.sv
module fb_fill_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [31:0] cmd_addr = '0;
    logic [31:0] cmd_pixel = '0;
    logic [1:0]  cmd_size = '0;
    logic [15:0] cmd_run = '0;
    logic [31:0] cmd_pitch = '0;
    logic [15:0] cmd_lines = '0;
    logic        wr_valid;
    logic        wr_ready = 1'b0;
    logic [31:0] wr_addr;
    logic [31:0] wr_data;
    logic [3:0]  wr_be;
    logic        wr_first;
    logic        wr_last;
    logic        done;

    int errors = 0;
    int checks = 0;

    logic [31:0] ex_addr  [2048];
    logic [31:0] ex_data  [2048];
    logic [3:0]  ex_be    [2048];
    logic        ex_first [2048];
    logic        ex_last  [2048];

    always #5 clk = ~clk;

    fb_fill_engine dut_i (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_addr  (cmd_addr),
        .cmd_pixel (cmd_pixel),
        .cmd_size  (cmd_size),
        .cmd_run   (cmd_run),
        .cmd_pitch (cmd_pitch),
        .cmd_lines (cmd_lines),
        .wr_valid  (wr_valid),
        .wr_ready  (wr_ready),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_be     (wr_be),
        .wr_first  (wr_first),
        .wr_last   (wr_last),
        .done      (done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int bytes_of(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    // expected beat list from R3..R7; returns number of beats
    function automatic int build(input logic [31:0] a, input logic [31:0] pix,
                                 input logic [1:0] sz, input int run,
                                 input int pitch, input int lines);
        int n = 0;
        int bpp = bytes_of(sz);
        if (run == 0 || lines == 0) return 0;
        for (int k = 0; k < lines; k++) begin
            longint la = longint'(a) + longint'(k) * longint'(pitch);
            longint ea = la + longint'(run * bpp) - 1;
            for (longint w = la / 4; w <= ea / 4; w++) begin
                ex_addr[n]  = 32'(w * 4);
                ex_first[n] = (w == la / 4);
                ex_last[n]  = (w == ea / 4);
                ex_be[n]    = '0;
                ex_data[n]  = '0;
                for (int i = 0; i < 4; i++) begin
                    longint b = w * 4 + i;
                    if (b >= la && b <= ea) begin
                        int sel = int'((b - la) % bpp);
                        ex_be[n][i] = 1'b1;
                        ex_data[n][i*8 +: 8] = pix[sel*8 +: 8];
                    end
                end
                n++;
            end
        end
        return n;
    endfunction

    task automatic run_cmd(input logic [31:0] a, input logic [31:0] pix,
                           input logic [1:0] sz, input int run, input int pitch,
                           input int lines, input int rdy_pct, input bit junk);
        int total = build(a, pix, sz, run, pitch, lines);
        int idx = 0;
        int beat_errs = 0;
        int guard = 0;
        bit prev_final;
        bit prev_stall = 0;
        logic [31:0] s_addr, s_data;
        logic [3:0]  s_be;
        logic        s_first, s_last;

        @(negedge clk);
        check(cmd_ready == 1'b1, "R1", "ready before command", cmd_ready, 1);
        cmd_valid = 1'b1;
        cmd_addr  = a;
        cmd_pixel = pix;
        cmd_size  = sz;
        cmd_run   = 16'(run);
        cmd_pitch = 32'(pitch);
        cmd_lines = 16'(lines);
        @(negedge clk);
        cmd_valid = junk;
        if (junk) begin
            cmd_addr  = a ^ 32'h0000_1235;
            cmd_pixel = ~pix;
            cmd_size  = sz + 2'd1;
            cmd_run   = 16'(run + 3);
            cmd_lines = 16'(lines + 2);
        end
        prev_final = (total == 0);
        while (1) begin
            if (prev_final) begin
                check(done == 1'b1, (total == 0) ? "R2" : "R8",
                      "done after final beat", done, 1);
                check(idx == total, "R7", "beat count", idx, total);
                break;
            end
            if (done) begin
                check(0, "R7", "early done, beats seen", idx, total);
                break;
            end
            if (prev_stall) begin
                check(wr_valid && wr_addr == s_addr && wr_data == s_data &&
                      wr_be == s_be && wr_first == s_first && wr_last == s_last,
                      "R9", "stalled beat changed", wr_addr, s_addr);
            end
            if (!wr_valid) begin
                check(0, "R4", "gap in write stream at beat", idx, total);
                break;
            end
            if (idx >= total) begin
                check(0, "R7", "extra beat addr", wr_addr, 0);
                break;
            end
            wr_ready = (($urandom % 100) < rdy_pct);
            if (wr_ready) begin
                logic [31:0] m = {{8{wr_be[3]}}, {8{wr_be[2]}}, {8{wr_be[1]}}, {8{wr_be[0]}}};
                bit ok_a = (wr_addr == ex_addr[idx]);
                bit ok_b = (wr_be == ex_be[idx]);
                bit ok_d = ((wr_data & m) == ex_data[idx]);
                bit ok_f = (wr_first == ex_first[idx] && wr_last == ex_last[idx]);
                check(ok_a, "R7", "beat address", wr_addr, ex_addr[idx]);
                check(ok_b, "R5", "byte enables", wr_be, ex_be[idx]);
                check(ok_d, "R6", "lane data", wr_data & m, ex_data[idx]);
                check(ok_f, "R4", "first/last", {wr_first, wr_last},
                      {ex_first[idx], ex_last[idx]});
                if (!(ok_a && ok_b && ok_d && ok_f)) beat_errs++;
                idx++;
                prev_final = (idx == total);
                prev_stall = 0;
            end else begin
                prev_stall = 1;
                s_addr = wr_addr; s_data = wr_data; s_be = wr_be;
                s_first = wr_first; s_last = wr_last;
            end
            guard++;
            if (guard > 20000) begin
                check(0, "R7", "command timeout, beats seen", idx, total);
                break;
            end
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        wr_ready  = 1'b0;
        if (junk) check(beat_errs == 0 && idx == total, "R10",
                        "busy request disturbed stream", beat_errs, 0);
        @(negedge clk);
        check(done == 1'b0 && cmd_ready == 1'b1, "R8", "pulse end / ready",
              {done, cmd_ready}, 2'b01);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(cmd_ready == 1'b1 && wr_valid == 1'b0 && done == 1'b0, "R1",
              "reset state", {cmd_ready, wr_valid, done}, 3'b100);

        // R3 R5 R6: 8-bit, two pixels inside one word
        run_cmd(32'h0000_0101, 32'h0000_00A5, 2'd0, 2, 64, 1, 100, 0);
        // R3 R6: vertical 16-bit line at odd start, odd pitch
        run_cmd(32'h0000_2003, 32'h0000_BEEF, 2'd1, 1, 1023, 8, 70, 0);
        // R6: 32-bit at offset 3, size code 3
        run_cmd(32'h0000_4007, 32'h1122_3344, 2'd3, 5, 37, 3, 60, 1);
        // R3: 32-bit aligned block
        run_cmd(32'h0001_0000, 32'hCAFE_F00D, 2'd2, 64, 4096, 8, 90, 0);
        // R2: empty commands
        run_cmd(32'h0000_0040, 32'h0000_0077, 2'd0, 0, 16, 5, 100, 0);
        run_cmd(32'h0000_0040, 32'h0000_0077, 2'd1, 9, 16, 0, 100, 1);
        // R7: zero pitch repeats the same line
        run_cmd(32'h0000_0802, 32'h0000_5A5A, 2'd1, 3, 0, 3, 50, 0);
        // R10 and random mix
        for (int t = 0; t < 40; t++) begin
            logic [1:0] sz = 2'($urandom % 4);
            int run   = ($urandom % 8 == 0) ? 0 : int'($urandom % 41);
            int lines = ($urandom % 8 == 0) ? 0 : int'($urandom % 7);
            int pitch = int'($urandom % 601);
            logic [31:0] a = $urandom % 32'h0010_0000;
            run_cmd(a, $urandom, sz, run, pitch, lines,
                    30 + int'($urandom % 71), ($urandom % 3) == 0);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule